// File: doc/BRIEF.md
# Serial Bit-Rate and Frame Timing Generator

This block holds the line-format configuration of a serial port and turns it into timing for the transmit and receive shifters. It keeps three configuration registers: a format word, a baud-generator count and a per-bit divider. Each has its own write strobe. A single bit of the format word chooses the rate source. The source is either every clock cycle or one cycle in eight, set by a fixed prescaler.

The baud-generator count divides the chosen source into a sample-rate enable. The per-bit divider, applied as (value + 1), then reduces that to a one-cycle bit-rate enable. The format word is also decoded into four settings for the shifters: data length, parity kind, stop-bit count and channel routing mode. From these the block works out the character length in bit times, which the receive-timeout logic uses.

Writing any of the three registers restarts all dividers from zero. This puts a new rate in phase with the write.

Top module: `baud_frame_timer`

## Requirements
- R1: After reset the format word is 0, the baud count is 15 and the per-bit divider is 0. The first sample enable is seen 15 cycles after reset release and the first bit enable 16 cycles after.
- R2: Format bit 0 set makes the rate source one pulse every 8 clock cycles. Format bit 0 clear makes the source every cycle.
- R3: The bit enable is a one-cycle pulse. Its period in clock cycles is source_period × count × (divider + 1).
- R4: Format bits [2:1] set the data length: 2'b11 gives 6, 2'b10 gives 7, and 2'b00 or 2'b01 gives 8.
- R5: Format bits [5:3] set parity: 3'b000 gives even (parity_en=1, parity_odd=0), 3'b001 gives odd (parity_en=1, parity_odd=1), and any other value gives none (both 0).
- R6: Format bits [7:6] set the stop bits: 2'b11 gives 1, and any other value gives 2.
- R7: Format bits [9:8] drive chan_mode unchanged: 0 normal, 1 echo, 2 local loopback, 3 remote loopback.
- R8: frame_bits equals 1 + data length + parity_en + stop bits, so it always lies in 8..12.
- R9: A baud count of 0 or 1 stops the generator. Neither enable pulses while that count is held.
- R10: A write to any of the three registers clears all divider state at that clock edge. No enable pulses in the cycle after the write. The first bit enable follows the write edge by one full bit period plus one cycle.
- R11: The sample enable is a one-cycle pulse every source_period × count cycles. After a write, the first one falls exactly that many cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_we | input | 1 | Format word write strobe |
| fmt_wdata | input | 10 | Format word write value |
| cnt_we | input | 1 | Baud-generator count write strobe |
| cnt_wdata | input | CD_W | Baud-generator count write value |
| div_we | input | 1 | Per-bit divider write strobe |
| div_wdata | input | DIV_W | Per-bit divider write value |
| sample_tick | output | 1 | Sample-rate enable pulse |
| bit_tick | output | 1 | Bit-rate enable pulse |
| data_bits | output | 4 | Data bits per character (6, 7 or 8) |
| parity_en | output | 1 | Parity bit present |
| parity_odd | output | 1 | Odd parity selected |
| stop_bits | output | 2 | Stop bits per character (1 or 2) |
| chan_mode | output | 2 | Channel routing mode |
| frame_bits | output | 4 | Character length in bit times |

## Verification
The bench builds the block with its defaults: a 16-bit count, an 8-bit divider and a prescale of 8. The reset value of 15 is then reachable within a short window. It programs counts of 2 to 5 and dividers of 0 to 3, with and without the prescaler. Every bit period is then 32 cycles or less, so first-pulse phase, the second-pulse spacing and pulse width all fit in one measurement window per vector. That includes the minimum enabled count of 2 and the disabling counts of 0 and 1.

// File: rtl/bft_pkg.sv
package bft_pkg;
   localparam int FMT_W = 10;

   typedef enum logic [1:0] {
      CH_NORMAL    = 2'd0,
      CH_ECHO      = 2'd1,
      CH_LOCAL_LB  = 2'd2,
      CH_REMOTE_LB = 2'd3
   } chan_e;

   typedef struct packed {
      logic [3:0] data_bits;
      logic       par_en;
      logic       par_odd;
      logic [1:0] stop_bits;
      chan_e      chan;
   } line_fmt_t;

   function automatic line_fmt_t decode_fmt(input logic [FMT_W-1:0] f);
      line_fmt_t r;
      unique case (f[2:1])
         2'b11:   r.data_bits = 4'd6;
         2'b10:   r.data_bits = 4'd7;
         default: r.data_bits = 4'd8;
      endcase
      r.par_en    = (f[5:4] == 2'b00);
      r.par_odd   = (f[5:3] == 3'b001);
      r.stop_bits = (f[7:6] == 2'b11) ? 2'd1 : 2'd2;
      r.chan      = chan_e'(f[9:8]);
      return r;
   endfunction
endpackage

// File: rtl/bft_prescaler.sv
module bft_prescaler #(
   parameter int PRE_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic sel,
   output logic src_en
);
   generate
      if (PRE_DIV == 1) begin : g_bypass
         assign src_en = 1'b1;
      end else begin : g_count
         localparam int            CW   = $clog2(PRE_DIV);
         localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);
         logic [CW-1:0] cnt_q;
         logic          wrap;

         assign wrap = (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (clear || !sel)  cnt_q <= '0;
            else                     cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         end

         // source pulses only on the last phase while prescaling is chosen
         assign src_en = !sel || wrap;
      end
   endgenerate
endmodule

// File: rtl/bft_rate_div.sv
module bft_rate_div #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         active,
   input  logic         en,
   input  logic [W-1:0] limit,
   output logic         tick
);
   logic [W-1:0] cnt_q;
   logic         at_end;

   assign at_end = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (clear || !active) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= en && at_end;
         if (en) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/bft_fmt_decode.sv
module bft_fmt_decode
   import bft_pkg::*;
(
   input  logic [FMT_W-1:0] fmt,
   output logic [3:0]       data_bits,
   output logic             parity_en,
   output logic             parity_odd,
   output logic [1:0]       stop_bits,
   output logic [1:0]       chan_mode,
   output logic [3:0]       frame_bits
);
   line_fmt_t lf;

   always_comb begin
      lf         = decode_fmt(fmt);
      data_bits  = lf.data_bits;
      parity_en  = lf.par_en;
      parity_odd = lf.par_odd;
      stop_bits  = lf.stop_bits;
      chan_mode  = lf.chan;
      // start bit + data + optional parity + stop bits
      frame_bits = 4'd1 + lf.data_bits + {3'b000, lf.par_en} + {2'b00, lf.stop_bits};
   end
endmodule

// File: rtl/baud_frame_timer.sv
module baud_frame_timer
   import bft_pkg::*;
#(
   parameter int          CD_W    = 16,
   parameter int          DIV_W   = 8,
   parameter int          PRE_DIV = 8,
   parameter int unsigned CD_RST  = 15,
   parameter int unsigned DIV_RST = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fmt_we,
   input  logic [9:0]       fmt_wdata,
   input  logic             cnt_we,
   input  logic [CD_W-1:0]  cnt_wdata,
   input  logic             div_we,
   input  logic [DIV_W-1:0] div_wdata,
   output logic             sample_tick,
   output logic             bit_tick,
   output logic [3:0]       data_bits,
   output logic             parity_en,
   output logic             parity_odd,
   output logic [1:0]       stop_bits,
   output logic [1:0]       chan_mode,
   output logic [3:0]       frame_bits
);
   localparam logic [CD_W-1:0] CD_MIN = CD_W'(2);

   generate
      if (CD_W < 2 || CD_W > 31) begin : g_bad_cd_w
         $error("CD_W must lie in 2..31");
      end
      if (DIV_W < 1 || DIV_W > 31) begin : g_bad_div_w
         $error("DIV_W must lie in 1..31");
      end
      if (PRE_DIV < 1) begin : g_bad_pre
         $error("PRE_DIV must be at least 1");
      end
      if ((CD_RST >> CD_W) != 0 || (DIV_RST >> DIV_W) != 0) begin : g_bad_rst
         $error("reset values exceed register widths");
      end
   endgenerate

   logic [FMT_W-1:0] fmt_q;
   logic [CD_W-1:0]  cd_q;
   logic [DIV_W-1:0] div_q;
   logic             any_we;
   logic             src_en;
   logic             gen_on;

   assign any_we = fmt_we || cnt_we || div_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q <= '0;
         cd_q  <= CD_W'(CD_RST);
         div_q <= DIV_W'(DIV_RST);
      end else begin
         if (fmt_we) fmt_q <= fmt_wdata;
         if (cnt_we) cd_q  <= cnt_wdata;
         if (div_we) div_q <= div_wdata;
      end
   end

   assign gen_on = (cd_q >= CD_MIN);

   bft_prescaler #(.PRE_DIV(PRE_DIV)) pre_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (any_we),
      .sel    (fmt_q[0]),
      .src_en (src_en)
   );

   bft_rate_div #(.W(CD_W)) cd_div_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (any_we),
      .active (gen_on),
      .en     (src_en),
      .limit  (cd_q - 1'b1),
      .tick   (sample_tick)
   );

   bft_rate_div #(.W(DIV_W)) bit_div_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (any_we),
      .active (gen_on),
      .en     (sample_tick),
      .limit  (div_q),
      .tick   (bit_tick)
   );

   bft_fmt_decode dec_i (
      .fmt        (fmt_q),
      .data_bits  (data_bits),
      .parity_en  (parity_en),
      .parity_odd (parity_odd),
      .stop_bits  (stop_bits),
      .chan_mode  (chan_mode),
      .frame_bits (frame_bits)
   );

   assert_reload_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      any_we |=> (!sample_tick && !bit_tick));

   assert_bit_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> $past(sample_tick));

   assert_bit_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> !bit_tick);

   assert_sample_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> !sample_tick);

   assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cd_q < CD_MIN) |=> !sample_tick);

   assert_frame_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_bits >= 4'd8) && (frame_bits <= 4'd12));
endmodule

// File: tb/baud_frame_timer_tb_top.sv
module baud_frame_timer_tb_top;
   localparam real CLK_HALF = 10.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fmt_we = 1'b0;
   logic [9:0]  fmt_wdata = '0;
   logic        cnt_we = 1'b0;
   logic [15:0] cnt_wdata = '0;
   logic        div_we = 1'b0;
   logic [7:0]  div_wdata = '0;
   logic        sample_tick, bit_tick, parity_en, parity_odd;
   logic [3:0]  data_bits, frame_bits;
   logic [1:0]  stop_bits, chan_mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   baud_frame_timer dut_i (
      .clk(clk), .rst_n(rst_n),
      .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
      .div_we(div_we), .div_wdata(div_wdata),
      .sample_tick(sample_tick), .bit_tick(bit_tick),
      .data_bits(data_bits), .parity_en(parity_en), .parity_odd(parity_odd),
      .stop_bits(stop_bits), .chan_mode(chan_mode), .frame_bits(frame_bits)
   );

   typedef struct packed {
      logic [9:0]  fmt;
      logic [15:0] cd;
      logic [7:0]  dv;
      logic [3:0]  data;
      logic        pen;
      logic        podd;
      logic [1:0]  stop;
      logic [1:0]  chan;
      logic [3:0]  frame;
      logic [15:0] period;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{10'h000, 16'd4, 8'd0, 4'd8, 1'b1, 1'b0, 2'd2, 2'd0, 4'd12, 16'd4},
      '{10'h0C6, 16'd3, 8'd2, 4'd6, 1'b1, 1'b0, 2'd1, 2'd0, 4'd9,  16'd9},
      '{10'h18D, 16'd2, 8'd1, 4'd7, 1'b1, 1'b1, 2'd2, 2'd1, 4'd11, 16'd32},
      '{10'h2E0, 16'd5, 8'd3, 4'd8, 1'b0, 1'b0, 2'd1, 2'd2, 4'd10, 16'd20},
      '{10'h37A, 16'd2, 8'd0, 4'd8, 1'b0, 1'b0, 2'd2, 2'd3, 4'd11, 16'd2},
      '{10'h017, 16'd3, 8'd0, 4'd6, 1'b0, 1'b0, 2'd2, 2'd0, 4'd9,  16'd24},
      '{10'h000, 16'd1, 8'd0, 4'd8, 1'b1, 1'b0, 2'd2, 2'd0, 4'd12, 16'd0},
      '{10'h0C0, 16'd0, 8'd2, 4'd8, 1'b1, 1'b0, 2'd1, 2'd0, 4'd11, 16'd0}
   };

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // drive selected registers for one cycle; returns half a cycle after the write edge
   task automatic wr(input bit wf, input logic [9:0] f, input bit wc, input logic [15:0] c,
                     input bit wd, input logic [7:0] d);
      @(negedge clk);
      fmt_we = wf; fmt_wdata = f;
      cnt_we = wc; cnt_wdata = c;
      div_we = wd; div_wdata = d;
      @(posedge clk);
      @(negedge clk);
      fmt_we = 1'b0; cnt_we = 1'b0; div_we = 1'b0;
   endtask

   // cycle index counts clock edges after the reference edge
   task automatic measure(input int win, output int fs, output int fb1, output int fb2,
                          output int dbl);
      bit prev = 1'b0;
      fs = 0; fb1 = 0; fb2 = 0; dbl = 0;
      for (int c = 1; c <= win; c++) begin
         @(negedge clk);
         if (sample_tick && fs == 0) fs = c;
         if (bit_tick) begin
            if (fb1 == 0) fb1 = c;
            else if (fb2 == 0) fb2 = c;
            if (prev) dbl++;
         end
         prev = bit_tick;
      end
   endtask

   initial begin
      #(CLK_HALF * 2.0 * 200000.0);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int fs, fb1, fb2, dbl, win, srcp;
      repeat (3) @(negedge clk);
      // R1 reset state of the decoded format (format word 0)
      chk("R1 data_bits", data_bits, 8);
      chk("R1 parity_en", parity_en, 1);
      chk("R1 frame_bits", frame_bits, 12);
      chk("R1 bit_tick low", bit_tick, 0);
      rst_n = 1'b1;
      measure(40, fs, fb1, fb2, dbl);
      chk("R1 first sample", fs, 15);
      chk("R1 first bit", fb1, 16);
      chk("R1 bit spacing", fb2 - fb1, 15);

      for (int i = 0; i < NV; i++) begin
         wr(1'b1, VECS[i].fmt, 1'b1, VECS[i].cd, 1'b1, VECS[i].dv);
         chk("R4 data_bits", data_bits, VECS[i].data);
         chk("R5 parity_en", parity_en, VECS[i].pen);
         chk("R5 parity_odd", parity_odd, VECS[i].podd);
         chk("R6 stop_bits", stop_bits, VECS[i].stop);
         chk("R7 chan_mode", chan_mode, VECS[i].chan);
         chk("R8 frame_bits", frame_bits, VECS[i].frame);
         win = (VECS[i].period == 0) ? 60 : 3 * int'(VECS[i].period) + 4;
         measure(win, fs, fb1, fb2, dbl);
         if (VECS[i].period == 0) begin
            chk("R9 no sample tick", fs, 0);
            chk("R9 no bit tick", fb1, 0);
         end else begin
            srcp = VECS[i].fmt[0] ? 8 : 1;
            chk("R10 first bit after write", fb1, int'(VECS[i].period) + 1);
            chk("R3 bit period", fb2 - fb1, int'(VECS[i].period));
            chk("R3 single-cycle pulse", dbl, 0);
            chk("R11 first sample", fs, srcp * int'(VECS[i].cd));
            if (VECS[i].fmt[0]) chk("R2 prescaled source", fs, 8 * int'(VECS[i].cd));
         end
      end

      // R2/R10: format-only write toggles the prescaler and restarts the dividers
      wr(1'b1, 10'h000, 1'b1, 16'd2, 1'b1, 8'd0);
      measure(10, fs, fb1, fb2, dbl);
      chk("R2 direct source spacing", fb2 - fb1, 2);
      wr(1'b1, 10'h001, 1'b0, 16'd0, 1'b0, 8'd0);
      measure(40, fs, fb1, fb2, dbl);
      chk("R2 prescale via format write", fs, 16);
      chk("R10 format write reload", fb1, 17);

      // R10: divider-only write mid-stream restarts phase
      wr(1'b1, 10'h000, 1'b1, 16'd5, 1'b1, 8'd0);
      repeat (3) @(negedge clk);
      wr(1'b0, 10'h000, 1'b0, 16'd0, 1'b1, 8'd1);
      measure(30, fs, fb1, fb2, dbl);
      chk("R10 divider write reload", fb1, 11);
      chk("R3 period with divider 1", fb2 - fb1, 10);

      // R9: count write to 1 silences output
      wr(1'b0, 10'h000, 1'b1, 16'd1, 1'b0, 8'd0);
      measure(50, fs, fb1, fb2, dbl);
      chk("R9 count 1 silent", fb1 + fs, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule